// File: doc/BRIEF.md
# Duty-Cycled Power-Fail Reset Sequencer

This block supervises the supply of a small microcontroller using three digital levels from outside comparators: above the power-on threshold, above the reset threshold and above the warning threshold. It holds the core in reset while the supply is too low. Once the supply recovers, it keeps reset asserted for a fixed stabilisation count before letting the core run. Once the core is running, a supply that drops below the warning threshold sets an interrupt flag. A supply that drops below the reset threshold puts the core back into reset.

The block also drives the power enable of the monitor comparators. While the core sits in power-fail reset with the supply between the power-on and reset thresholds, a software-set 2-bit interval code can turn the monitor on briefly once per interval instead of keeping it on. This saves current and stretches the time before the supply reaches the power-on threshold. In stop mode, software can turn the monitor off, but only when the regulator is also off. The monitor comes back on before the core leaves stop mode, and that check decides whether the core resumes or goes into reset.

Top module: `pfr_sequencer`

## Requirements
- R1: After the synchronised reset-level input is seen high while in reset, `sys_rst` stays 1 for at least STAB_CYCLES (8192) further clock cycles and falls within 4 cycles after that.
- R2: In run state, a warning-level input held low sets `warn_flag` within 4 cycles. `warn_irq` equals `warn_flag` when `irq_en` is 1 and is 0 otherwise. `warn_clr` clears the flag once the warning input is high again.
- R3: The interval setting `chk_cfg` is loaded by `chk_wr` and is cleared only by `por_n` low. A reset-level event leaves it unchanged. Its reset value is 00.
- R4: In reset with `chk_cfg` = 00, `mon_en` is 1 on every cycle. With codes 01, 10 and 11, `mon_en` is 1 for exactly 3 cycles in every 512, 1024 and 2048 cycles respectively.
- R5: `por_flag` is 0 after `por_n` low and becomes 1 when `sys_rst` falls. It stays 1 until `por_clr` is pulsed.
- R6: In run state, `mon_en` is 0 exactly when `stop_mode`=1, `reg_on`=0 and `mon_off_req`=1. Otherwise it is 1.
- R7: While the monitor is off in stop mode, reset-level and warning-level inputs have no effect on `sys_rst` or `warn_flag`.
- R8: On stop exit, the monitor turns back on. A low warning input then sets `warn_flag`, and a low reset-level input then raises `sys_rst`.
- R9: `por_n` low forces `sys_rst`=1 at once, without a clock edge.
- R10: In run state with the monitor on, a reset-level input held low raises `sys_rst` within 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| rst_lvl_ok | input | 1 | Supply above reset threshold (asynchronous) |
| warn_lvl_ok | input | 1 | Supply above warning threshold (asynchronous) |
| stop_mode | input | 1 | Core is in stop mode |
| reg_on | input | 1 | Regulator kept on in stop mode |
| mon_off_req | input | 1 | Request to turn the monitor off in stop mode |
| chk_wr | input | 1 | Write strobe for the interval setting |
| chk_wdata | input | 2 | Interval code to write |
| irq_en | input | 1 | Warning interrupt enable |
| warn_clr | input | 1 | Software clear of the warning flag |
| por_clr | input | 1 | Software clear of the power-on flag |
| sys_rst | output | 1 | Internal reset, active high |
| warn_flag | output | 1 | Power-fail warning flag |
| warn_irq | output | 1 | Warning interrupt request |
| por_flag | output | 1 | Sticky flag set when the core leaves supply reset |
| mon_en | output | 1 | Power enable for the monitor comparators |
| chk_cfg | output | 2 | Current interval setting |

## Verification
The hardest case to reach is a supply that drops while the monitor is switched off in stop mode, because this state needs a particular combination of run state, stop mode and regulator setting. The bench first leaves reset fully and then enters gated stop. It lowers the comparator inputs and confirms that nothing happens. It then leaves stop mode and checks that the check made on re-enable either sets the warning flag or puts the core back into reset. That reset is then used to measure the duty cycle for each interval code. Each measurement counts `mon_en` high cycles over a 2048-cycle span, so the result does not depend on the counter's phase.

// File: rtl/pfr_sequencer.sv
module pfr_sequencer #(
  parameter int STAB_CYCLES = 8192,
  parameter int BASE_PERIOD = 512,
  parameter int ON_CYCLES   = 3
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_lvl_ok,
  input  logic       warn_lvl_ok,
  input  logic       stop_mode,
  input  logic       reg_on,
  input  logic       mon_off_req,
  input  logic       chk_wr,
  input  logic [1:0] chk_wdata,
  input  logic       irq_en,
  input  logic       warn_clr,
  input  logic       por_clr,
  output logic       sys_rst,
  output logic       warn_flag,
  output logic       warn_irq,
  output logic       por_flag,
  output logic       mon_en,
  output logic [1:0] chk_cfg
);

  localparam int MAXP = BASE_PERIOD * 4;
  localparam int PW   = $clog2(MAXP);
  localparam int SW   = $clog2(STAB_CYCLES);

  typedef enum logic [1:0] {S_HOLD, S_STAB, S_RUN} st_t;

  st_t           state;
  logic [1:0]    rs, ws, live_p;
  logic [PW-1:0] hcnt, period_m1;
  logic [SW-1:0] scnt;
  logic          duty, mon_live, stop_gate;

  always_comb begin
    case (chk_cfg)
      2'd1:    period_m1 = PW'(BASE_PERIOD - 1);
      2'd2:    period_m1 = PW'(BASE_PERIOD * 2 - 1);
      default: period_m1 = PW'(BASE_PERIOD * 4 - 1);
    endcase
  end

  assign duty      = (state == S_HOLD) && (chk_cfg != 2'd0);
  assign stop_gate = stop_mode && !reg_on && mon_off_req;
  assign mon_en    = duty ? (hcnt >= period_m1 - PW'(ON_CYCLES - 1))
                          : ((state != S_RUN) || !stop_gate);
  assign mon_live  = mon_en && live_p[1];
  assign sys_rst   = (state != S_RUN) || !por_n;
  assign warn_irq  = warn_flag && irq_en;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rs     <= 2'b00;
      ws     <= 2'b00;
      live_p <= 2'b00;
    end else begin
      rs     <= {rs[0], rst_lvl_ok};
      ws     <= {ws[0], warn_lvl_ok};
      live_p <= {live_p[0], mon_en};
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chk_cfg <= 2'd0;
    else if (chk_wr) chk_cfg <= chk_wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) hcnt <= '0;
    else if (!duty || hcnt >= period_m1) hcnt <= '0;
    else hcnt <= hcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= S_HOLD;
      scnt  <= '0;
    end else begin
      case (state)
        S_HOLD: begin
          scnt <= '0;
          if (mon_live && rs[1]) state <= S_STAB;
        end
        S_STAB: begin
          scnt <= scnt + 1'b1;
          if (mon_live && !rs[1]) state <= S_HOLD;
          else if (scnt == SW'(STAB_CYCLES - 1)) state <= S_RUN;
        end
        default: begin
          scnt <= '0;
          if (mon_live && !rs[1]) state <= S_HOLD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      warn_flag <= 1'b0;
      por_flag  <= 1'b0;
    end else begin
      if (state == S_RUN && mon_live && !ws[1]) warn_flag <= 1'b1;
      else if (warn_clr) warn_flag <= 1'b0;
      if (state == S_STAB && !(mon_live && !rs[1]) && scnt == SW'(STAB_CYCLES - 1))
        por_flag <= 1'b1;
      else if (por_clr) por_flag <= 1'b0;
    end
  end

  a_r2_irq_needs_flag: assert property (@(posedge clk) disable iff (!por_n)
    warn_irq |-> warn_flag);

  a_r3_cfg_held: assert property (@(posedge clk) disable iff (!por_n)
    !chk_wr |=> $stable(chk_cfg));

  a_r4_window_min: assert property (@(posedge clk) disable iff (!por_n)
    (duty && $rose(mon_en) && $stable(chk_cfg)) |=> mon_en);

  a_r5_flag_on_release: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> por_flag);

  a_r6_gate_off: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && stop_mode && !reg_on && mon_off_req) |-> !mon_en);

  a_r6_reg_keeps_on: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && stop_mode && reg_on) |-> mon_en);

  a_r7_gated_no_reset: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && !mon_en) |=> !sys_rst);

  a_r7_gated_no_warn: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && !mon_en && !warn_flag) |=> !warn_flag);

endmodule

// File: tb/sim_pfr_sequencer.sv
module sim_pfr_sequencer;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_lvl_ok = 1'b0, warn_lvl_ok = 1'b0;
  logic stop_mode = 1'b0, reg_on = 1'b0, mon_off_req = 1'b0;
  logic chk_wr = 1'b0, irq_en = 1'b0, warn_clr = 1'b0, por_clr = 1'b0;
  logic [1:0] chk_wdata = 2'd0;
  logic sys_rst, warn_flag, warn_irq, por_flag, mon_en;
  logic [1:0] chk_cfg;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pfr_sequencer u0 (.*);

  // {stop_mode, reg_on, mon_off_req, expected mon_en}
  localparam logic [3:0] GATE_VEC [8] = '{
    4'b000_1, 4'b001_1, 4'b010_1, 4'b011_1,
    4'b100_1, 4'b101_0, 4'b110_1, 4'b111_1};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (sys_rst && n < 20000) begin tick(1); n++; end
  endtask

  task automatic count_on(output int n);
    n = 0;
    for (int i = 0; i < 2048; i++) begin tick(1); n += int'(mon_en); end
  endtask

  task automatic write_cfg(input logic [1:0] v);
    chk_wdata = v; chk_wr = 1'b1; tick(1); chk_wr = 1'b0;
  endtask

  initial begin
    int n;
    tick(3);
    check("R9 reset sys_rst", sys_rst, 1);
    check("R5 reset por_flag", por_flag, 0);
    check("R3 reset chk_cfg", chk_cfg, 0);
    check("R4 reset mon_en", mon_en, 1);
    por_n = 1'b1; warn_lvl_ok = 1'b1;
    tick(10);
    check("R1 still held", sys_rst, 1);
    rst_lvl_ok = 1'b1;
    wait_release(n);
    check("R1 release not early", int'(n >= 8192), 1);
    check("R1 release not late", int'(n <= 8196), 1);
    check("R5 por_flag set", por_flag, 1);

    for (int i = 0; i < 8; i++) begin
      {stop_mode, reg_on, mon_off_req} = GATE_VEC[i][3:1];
      tick(1);
      check("R6 gate table", mon_en, GATE_VEC[i][0]);
    end
    stop_mode = 1'b0; reg_on = 1'b0; mon_off_req = 1'b0;
    tick(4);
    check("R6 run sys_rst", sys_rst, 0);

    warn_lvl_ok = 1'b0; tick(5);
    check("R2 flag set", warn_flag, 1);
    check("R2 irq masked", warn_irq, 0);
    irq_en = 1'b1; tick(1);
    check("R2 irq enabled", warn_irq, 1);
    warn_lvl_ok = 1'b1; tick(4);
    warn_clr = 1'b1; tick(1); warn_clr = 1'b0; tick(1);
    check("R2 flag cleared", warn_flag, 0);
    por_clr = 1'b1; tick(1); por_clr = 1'b0; tick(1);
    check("R5 por_flag cleared", por_flag, 0);

    stop_mode = 1'b1; reg_on = 1'b0; mon_off_req = 1'b1; tick(2);
    warn_lvl_ok = 1'b0; rst_lvl_ok = 1'b0; tick(20);
    check("R7 gated no reset", sys_rst, 0);
    check("R7 gated no warn", warn_flag, 0);
    rst_lvl_ok = 1'b1; tick(4);
    stop_mode = 1'b0; tick(5);
    check("R8 exit warn", warn_flag, 1);
    check("R8 exit no reset", sys_rst, 0);
    warn_lvl_ok = 1'b1; tick(4);
    warn_clr = 1'b1; tick(1); warn_clr = 1'b0;
    stop_mode = 1'b1; tick(2);
    rst_lvl_ok = 1'b0; tick(10);
    check("R7 gated rst low", sys_rst, 0);
    stop_mode = 1'b0; tick(5);
    check("R8 exit reset", sys_rst, 1);

    count_on(n); check("R4 code 00", n, 2048);
    write_cfg(2'd1); count_on(n); check("R4 code 01", n, 12);
    write_cfg(2'd2); count_on(n); check("R4 code 10", n, 6);
    write_cfg(2'd3); count_on(n); check("R4 code 11", n, 3);
    check("R3 cfg kept over reset event", chk_cfg, 3);
    rst_lvl_ok = 1'b1;
    wait_release(n);
    check("R1 release after duty", int'(n >= 8192 && n <= 2048 + 8196), 1);
    check("R5 por_flag set again", por_flag, 1);

    rst_lvl_ok = 1'b0; tick(5);
    check("R10 run reset", sys_rst, 1);
    rst_lvl_ok = 1'b1;
    wait_release(n);
    #1 por_n = 1'b0; #0.5;
    check("R9 async reset", sys_rst, 1);
    tick(2); por_n = 1'b1; tick(2);
    check("R3 cleared by por", chk_cfg, 0);
    check("R5 cleared by por", por_flag, 0);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule